// File: doc/BRIEF.md
# Power-Up Configuration Start Sequencer

This block decides when a programmable device may begin loading its configuration after power comes up or after a reprogram request. On leaving reset it waits for a power-on interval whose length depends on one mode strap. It then issues memory-clear passes to an external clearing engine through a start/done handshake. While the active-low program input is held low, a new pass begins each time the previous one finishes. Once program is released, one further clean pass must complete before the sequence can move on.

During the power-on wait and every clear pass the block pulls the shared open-drain init line low. After clearing it stops pulling and stalls until the line is seen high, which lets any other device hold the start back. When the line is high it latches the three mode straps. For a master mode it counts an extra settle window so that every device on the chain has seen init high. It then pulses a start-configuration strobe. A later program request at any point sends the block back to clearing.

Top module: `cfg_start_seq`

## Requirements
- R1: After reset is released, the first clear-start pulse appears exactly POR_SHORT_CYC cycles later when mode_pins[0] is 1, and exactly POR_LONG_CYC cycles later when mode_pins[0] is 0.
- R2: init_drive_low is 1 during reset, throughout the power-on wait, and in every cycle in which clr_start is high.
- R3: While prog_n is held low, clear passes repeat back to back, so at least two passes start during a low period of 24 cycles when each pass takes six cycles.
- R4: After prog_n rises, exactly one more clear pass starts at or after the second cycle following the release, and the block then leaves clearing.
- R5: After clearing, while the init line is held low externally, init_drive_low is 0 and no start_cfg pulse occurs.
- R6: When init is seen high, cfg_mode takes the value of mode_pins and cfg_master becomes 1 exactly when mode_pins[1:0] is 2'b00. The captured values hold while start_cfg is issued.
- R7: start_cfg rises 3 cycles after init goes high for a non-master mode, and 3 + MASTER_WAIT_CYC cycles after for a master mode.
- R8: start_cfg is a single-cycle pulse, issued once per sequence.
- R9: When prog_n falls, from any state after the power-on wait, init_drive_low is 1 two cycles later and clr_start is 1 three cycles later.
- R10: clr_start is a one-cycle pulse, and no new pass starts before clr_done has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing in for power-on detection |
| prog_n | input | 1 | Asynchronous program request, active low |
| init_in | input | 1 | Sampled level of the shared open-drain init line |
| mode_pins | input | 3 | Configuration mode straps, assumed static |
| clr_done | input | 1 | One-cycle pulse from the clearing engine when a pass completes |
| init_drive_low | output | 1 | Enable for the open-drain pull-down on the init line |
| clr_start | output | 1 | One-cycle pulse that starts a memory-clear pass |
| start_cfg | output | 1 | One-cycle pulse that starts configuration |
| cfg_mode | output | 3 | Mode straps captured when init was seen high |
| cfg_master | output | 1 | The captured mode is a master mode |

## Verification
The hardest case to reach is releasing program while a clear pass is still running, because that pass must not count as the final one. The bench holds program low across several passes driven by a clearing-engine model with a fixed latency. It releases program in mid-pass and counts the pass starts seen from the second cycle after the release, expecting exactly one. The stall on an externally held init line is produced by a wired-AND model of the line, with the bench's own pull-down held until the stall has been observed for many cycles.

// File: rtl/cfg_start_pkg.sv
`timescale 1ns/1ps
package cfg_start_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_POR,
        ST_CLR_GO,
        ST_CLR_WAIT,
        ST_INIT_WAIT,
        ST_SETTLE,
        ST_START,
        ST_RUN
    } seq_state_t;

    typedef struct packed {
        logic [MODE_W-1:0] pins;
        logic              master;
    } mode_cap_t;

    function automatic logic is_master_mode(input logic [MODE_W-1:0] m);
        return (m[1:0] == 2'b00);
    endfunction

    function automatic logic state_pulls_init(input seq_state_t s);
        return (s == ST_POR) || (s == ST_CLR_GO) || (s == ST_CLR_WAIT);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int r;
        r = (a > b) ? a : b;
        return (r > c) ? r : c;
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
`timescale 1ns/1ps
module cfg_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/cfg_cycle_timer.sv
`timescale 1ns/1ps
module cfg_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == (limit - TW'(1)));
endmodule

// File: rtl/cfg_seq_fsm.sv
`timescale 1ns/1ps
module cfg_seq_fsm
    import cfg_start_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_low,
    input  logic              init_high,
    input  logic              clr_done,
    input  logic              tmr_hit,
    input  logic [MODE_W-1:0] mode_pins,
    output seq_state_t        state,
    output logic              clr_start,
    output logic              start_cfg,
    output logic              init_drive_low,
    output logic              tmr_run,
    output mode_cap_t         mode_q
);
    seq_state_t nxt;
    logic       dirty;

    always_comb begin
        nxt = state;
        case (state)
            ST_POR:       if (tmr_hit) nxt = ST_CLR_GO;
            ST_CLR_GO:    nxt = ST_CLR_WAIT;
            ST_CLR_WAIT:  if (clr_done) nxt = (dirty || prog_low) ? ST_CLR_GO : ST_INIT_WAIT;
            ST_INIT_WAIT: begin
                if (prog_low)       nxt = ST_CLR_GO;
                else if (init_high) nxt = is_master_mode(mode_pins) ? ST_SETTLE : ST_START;
            end
            ST_SETTLE: begin
                if (prog_low)     nxt = ST_CLR_GO;
                else if (tmr_hit) nxt = ST_START;
            end
            ST_START:     nxt = prog_low ? ST_CLR_GO : ST_RUN;
            ST_RUN:       if (prog_low) nxt = ST_CLR_GO;
            default:      nxt = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_POR;
            dirty  <= 1'b0;
            mode_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CLR_GO)
                dirty <= prog_low;
            else if (state == ST_CLR_WAIT && prog_low)
                dirty <= 1'b1;
            if (state == ST_INIT_WAIT && !prog_low && init_high) begin
                mode_q.pins   <= mode_pins;
                mode_q.master <= is_master_mode(mode_pins);
            end
        end
    end

    assign clr_start      = (state == ST_CLR_GO);
    assign start_cfg      = (state == ST_START);
    assign init_drive_low = state_pulls_init(state) || prog_low;
    assign tmr_run        = (state == ST_POR) || (state == ST_SETTLE);
endmodule

// File: rtl/cfg_start_seq.sv
`timescale 1ns/1ps
module cfg_start_seq
    import cfg_start_pkg::*;
#(
    parameter int POR_SHORT_CYC   = 500000,
    parameter int POR_LONG_CYC    = 2000000,
    parameter int MASTER_WAIT_CYC = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_n,
    input  logic              init_in,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              clr_done,
    output logic              init_drive_low,
    output logic              clr_start,
    output logic              start_cfg,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_master
);
    localparam int TMAX = max3(POR_SHORT_CYC, POR_LONG_CYC, MASTER_WAIT_CYC);
    localparam int TW   = $clog2(TMAX + 1);

    logic [1:0]    sync_q;
    logic          prog_low, init_high;
    logic          tmr_run, tmr_hit;
    logic [TW-1:0] tmr_limit;
    seq_state_t    state;
    mode_cap_t     mode_q;

    cfg_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({prog_n, init_in}),
        .q   (sync_q)
    );

    assign prog_low  = !sync_q[1];
    assign init_high = sync_q[0];

    always_comb begin
        if (state == ST_SETTLE)  tmr_limit = TW'(MASTER_WAIT_CYC);
        else if (mode_pins[0])   tmr_limit = TW'(POR_SHORT_CYC);
        else                     tmr_limit = TW'(POR_LONG_CYC);
    end

    cfg_cycle_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (tmr_run),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    cfg_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .prog_low       (prog_low),
        .init_high      (init_high),
        .clr_done       (clr_done),
        .tmr_hit        (tmr_hit),
        .mode_pins      (mode_pins),
        .state          (state),
        .clr_start      (clr_start),
        .start_cfg      (start_cfg),
        .init_drive_low (init_drive_low),
        .tmr_run        (tmr_run),
        .mode_q         (mode_q)
    );

    assign cfg_mode   = mode_q.pins;
    assign cfg_master = mode_q.master;
endmodule

// File: rtl/cfg_start_chk.sv
`timescale 1ns/1ps
module cfg_start_chk
    import cfg_start_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              prog_n,
    input logic              clr_done,
    input logic              init_drive_low,
    input logic              clr_start,
    input logic              start_cfg,
    input logic [MODE_W-1:0] cfg_mode
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)            pending <= 1'b0;
        else if (clr_start) pending <= 1'b1;
        else if (clr_done)  pending <= 1'b0;
    end

    p_clr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        clr_start |=> !clr_start);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        clr_start |-> !pending);

    p_clear_pulls_r2: assert property (@(posedge clk) disable iff (rst)
        clr_start |-> init_drive_low);

    p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        start_cfg |=> !start_cfg);

    p_start_after_clear_r4: assert property (@(posedge clk) disable iff (rst)
        start_cfg |-> !pending);

    p_start_released_r5: assert property (@(posedge clk) disable iff (rst)
        (start_cfg && $past(prog_n) && $past(prog_n, 2)) |-> !init_drive_low);

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
        start_cfg |=> $stable(cfg_mode));
endmodule

bind cfg_start_seq cfg_start_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .prog_n         (prog_n),
    .clr_done       (clr_done),
    .init_drive_low (init_drive_low),
    .clr_start      (clr_start),
    .start_cfg      (start_cfg),
    .cfg_mode       (cfg_mode)
);

// File: tb/sim_cfg_start_seq.sv
`timescale 1ns/1ps
module sim_cfg_start_seq;
    import cfg_start_pkg::*;

    localparam int PS  = 8;
    localparam int PL  = 20;
    localparam int MW  = 12;
    localparam int LAT = 4;

    // each entry: {mode_pins[2:0], expected master flag}
    localparam logic [3:0] VEC [6] = '{4'b0001, 4'b0010, 4'b0100, 4'b1001, 4'b1110, 4'b0110};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, prog_n, ext_low, clr_done;
    logic [2:0] mode_pins;
    logic       init_in, init_drive_low, clr_start, start_cfg, cfg_master;
    logic [2:0] cfg_mode;

    assign init_in = !init_drive_low && !ext_low;

    int checks = 0, fails = 0, pass_cnt = 0, start_cnt = 0;
    logic busy;
    int   lat;

    cfg_start_seq #(.POR_SHORT_CYC(PS), .POR_LONG_CYC(PL), .MASTER_WAIT_CYC(MW)) u0 (
        .clk            (clk),
        .rst            (rst),
        .prog_n         (prog_n),
        .init_in        (init_in),
        .mode_pins      (mode_pins),
        .clr_done       (clr_done),
        .init_drive_low (init_drive_low),
        .clr_start      (clr_start),
        .start_cfg      (start_cfg),
        .cfg_mode       (cfg_mode),
        .cfg_master     (cfg_master)
    );

    // clearing engine model: done pulse a fixed latency after each start
    always @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            lat      <= 0;
            clr_done <= 1'b0;
        end else begin
            clr_done <= 1'b0;
            if (clr_start) begin
                busy <= 1'b1;
                lat  <= LAT;
            end else if (busy) begin
                if (lat == 1) begin
                    clr_done <= 1'b1;
                    busy     <= 1'b0;
                end
                lat <= lat - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (clr_start) pass_cnt++;
            if (start_cfg) start_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic por_run(input logic [2:0] m, input int exp);
        int n;
        rst = 1'b1; mode_pins = m; prog_n = 1'b1; ext_low = 1'b1;
        tick(3);
        chk(clr_start == 1'b0, "R10 reset clr_start", int'(clr_start), 0);
        chk(start_cfg == 1'b0, "R8 reset start_cfg", int'(start_cfg), 0);
        chk(init_drive_low == 1'b1, "R2 reset init pull", int'(init_drive_low), 1);
        rst = 1'b0;
        n = 0;
        do begin
            tick(1);
            n++;
            if (n < exp && !clr_start)
                if (!init_drive_low) chk(0, "R2 por init pull", 0, 1);
        end while (!clr_start && n < 200);
        chk(n == exp, "R1 por length", n, exp);
        chk(init_drive_low == 1'b1, "R2 first pass init pull", int'(init_drive_low), 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p0, s0, n;
        rst = 1'b1; prog_n = 1'b1; ext_low = 1'b1; mode_pins = 3'b001;

        por_run(3'b001, PS);
        por_run(3'b000, PL);

        // R3 / R4: hold program low across passes, release mid-pass
        prog_n = 1'b0;
        p0 = pass_cnt;
        tick(24);
        chk((pass_cnt - p0) >= 2, "R3 repeated passes", pass_cnt - p0, 2);
        chk((pass_cnt - p0) <= 5, "R10 pass rate", pass_cnt - p0, 5);
        prog_n = 1'b1;
        tick(1);
        p0 = pass_cnt;
        tick(30);
        chk((pass_cnt - p0) == 1, "R4 one clean pass", pass_cnt - p0, 1);
        chk(init_drive_low == 1'b0, "R5 released after clear", int'(init_drive_low), 0);
        chk(start_cnt == 0, "R5 stall no start", start_cnt, 0);

        for (int i = 0; i < 6; i++) begin
            logic [2:0] m;
            logic       ms;
            int         exp;
            m  = VEC[i][3:1];
            ms = VEC[i][0];
            mode_pins = m;
            ext_low   = 1'b1;
            prog_n    = 1'b0;
            tick(2);
            chk(init_drive_low == 1'b1, "R9 program pulls init", int'(init_drive_low), 1);
            tick(1);
            chk(clr_start == 1'b1, "R9 program starts clear", int'(clr_start), 1);
            tick(3);
            prog_n = 1'b1;
            tick(30);
            s0 = start_cnt;
            tick(10);
            chk(start_cnt == s0, "R5 stall while init held", start_cnt - s0, 0);
            chk(init_drive_low == 1'b0, "R5 no pull while stalled", int'(init_drive_low), 0);
            ext_low = 1'b0;
            n = 0;
            do begin
                tick(1);
                n++;
            end while (!start_cfg && n < 200);
            exp = ms ? (3 + MW) : 3;
            chk(n == exp, "R7 start latency", n, exp);
            chk(cfg_mode == m, "R6 captured mode", int'(cfg_mode), int'(m));
            chk(cfg_master == ms, "R6 master flag", int'(cfg_master), int'(ms));
            tick(1);
            chk(start_cfg == 1'b0, "R8 start one cycle", int'(start_cfg), 0);
            tick(5);
            chk((start_cnt - s0) == 1, "R8 single start", start_cnt - s0, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule